// File: doc/BRIEF.md
# Shared-Bus EPROM Bank Read Sequencer

This block drives the control strobes for a bank of byte-wide parallel EPROMs whose data outputs all sit on one shared bus. A read request carries a system address. The high bits of that address pick one device, and the low bits go unchanged to every device. Each device gets its own active-low chip enable, taken from the address decode. That enable is the device select and also its power gate. One active-low output enable is shared by the whole bank and is asserted only while a read is in progress.

Each access follows a fixed sequence. The chip enable falls first. The shared output enable falls later, placed so that the chip-enable path (`ACC_CYC` cycles) and the output-enable path (`OE_CYC` cycles) finish on the same clock cycle. The bus is sampled on that cycle. The output enable is then released one cycle before the chip enable, so two devices never drive the bus together, even when the next access selects a different device. The captured byte is returned with a one-cycle done pulse.

Top module: `rom_bank_reader`

## Requirements
- R1: While reset is active and on the first cycle after it, every `chip_ce_n` bit is 1, `out_en_n` is 1, `rd_done` is 0 and `rd_ready` is 1.
- R2: An accepted request with address A drives `chip_ce_n[i]` low, where i = A[DEV_AW+SEL_W-1:DEV_AW]. No other bit of `chip_ce_n` is low. A[DEV_AW-1:0] appears on `dev_addr`.
- R3: No more than one bit of `chip_ce_n` is low on any cycle, so no more than one device can drive the data bus.
- R4: `out_en_n` is low only while exactly one chip enable is low.
- R5: Take the edge that accepts a request as cycle 0. The chip enable is low from cycle 1 through cycle ACC_CYC+1. `out_en_n` is low from cycle ACC_CYC-OE_CYC+1 through cycle ACC_CYC, which is exactly OE_CYC cycles.
- R6: `out_en_n` is already high on the cycle before the chip enable returns high.
- R7: `dev_data` is sampled on cycle ACC_CYC. On cycle ACC_CYC+2, `rd_done` is high for one cycle and `rd_data` holds the sampled byte.
- R8: A request is accepted only on a cycle where `rd_ready` is 1. `rd_ready` is 0 from cycle 1 through cycle ACC_CYC+1, and any request made in that window is ignored. If `rd_req` is held high, a new access is accepted on the done cycle.
- R9: While a chip enable stays low, `dev_addr` and `chip_ce_n` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, sampled when `rd_ready` is high |
| rd_addr | input | DEV_AW+SEL_W | System byte address; the top bits select the device |
| rd_ready | output | 1 | Sequencer is idle and will accept a request |
| rd_done | output | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | output | DW | Byte captured from the bank |
| dev_addr | output | DEV_AW | Address driven to every device |
| chip_ce_n | output | N_CHIPS | Per-device active-low chip enable |
| out_en_n | output | 1 | Shared active-low output enable |
| dev_data | input | DW | Resolved shared data bus of the bank |

## Verification
The bound checker checks on every cycle that at most one chip enable is low and that the output enable is never low without a selected device. It also checks that the output enable rises before the chip enable is released, that address and selection hold steady during an access, that done lasts one cycle, and that the sample point falls inside the output-enable window. Only the bench's scenarios can show the cycle positions of each edge and the correctness of the returned byte. For this, the bench uses device models that return wrong data until their own enable-to-data and output-enable-to-data latencies have passed. The bench also covers requests that arrive while busy, and requests held high across back-to-back reads.

// File: rtl/rom_bank_pkg.sv
`timescale 1ns/1ps
package rom_bank_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RELEASE = 2'd2
  } rb_state_e;

  // Cycles between the chip enable falling and the output enable falling,
  // chosen so that both delay paths end on the same cycle.
  function automatic int unsigned rb_oe_lead(input int unsigned acc_cyc,
                                             input int unsigned oe_cyc);
    return (acc_cyc > oe_cyc) ? (acc_cyc - oe_cyc) : 0;
  endfunction

  // Width of the device-select field for a given device count.
  function automatic int unsigned rb_sel_width(input int unsigned n_chips);
    return (n_chips > 1) ? $clog2(n_chips) : 1;
  endfunction

  // Width of a counter that must reach acc_cyc.
  function automatic int unsigned rb_cnt_width(input int unsigned acc_cyc);
    return (acc_cyc > 1) ? $clog2(acc_cyc + 1) : 1;
  endfunction

endpackage

// File: rtl/rom_bank_decode.sv
`timescale 1ns/1ps
module rom_bank_decode #(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic               en,
  output logic [N_CHIPS-1:0] ce_n
);
  // One comparator per device; an enable is low only for the matching select.
  for (genvar gi = 0; gi < N_CHIPS; gi++) begin : g_ce
    assign ce_n[gi] = ~(en && (sel == SEL_W'(gi)));
  end
endmodule

// File: rtl/rom_bank_timer.sv
`timescale 1ns/1ps
module rom_bank_timer #(
  parameter int unsigned ACC_CYC = 6,
  parameter int unsigned LEAD    = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic oe_set,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  // cnt holds the number of full cycles the chip enable has been low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= cnt + CNT_W'(1);
  end

  if (LEAD == 0) begin : g_oe_now
    assign oe_set = start;
  end else begin : g_oe_late
    assign oe_set = run && (cnt == CNT_W'(LEAD - 1));
  end

  assign last = run && (cnt == CNT_W'(ACC_CYC - 1));
endmodule

// File: rtl/rom_bank_capture.sv
`timescale 1ns/1ps
module rom_bank_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          rel,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] data,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      done <= 1'b0;
    end else begin
      if (cap) data <= bus;
      done <= rel;
    end
  end
endmodule

// File: rtl/rom_bank_reader.sv
`timescale 1ns/1ps
module rom_bank_reader
  import rom_bank_pkg::*;
#(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned DEV_AW  = 20,
  parameter int unsigned DW      = 8,
  parameter int unsigned ACC_CYC = 6,   // chip enable to data, cycles (>= 1)
  parameter int unsigned OE_CYC  = 2,   // output enable to data, cycles (1..ACC_CYC)
  localparam int unsigned SEL_W  = rb_sel_width(N_CHIPS),
  localparam int unsigned SYS_AW = DEV_AW + SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic [SYS_AW-1:0]   rd_addr,
  output logic                rd_ready,
  output logic                rd_done,
  output logic [DW-1:0]       rd_data,
  output logic [DEV_AW-1:0]   dev_addr,
  output logic [N_CHIPS-1:0]  chip_ce_n,
  output logic                out_en_n,
  input  logic [DW-1:0]       dev_data
);
  localparam int unsigned LEAD  = rb_oe_lead(ACC_CYC, OE_CYC);
  localparam int unsigned CNT_W = rb_cnt_width(ACC_CYC);

  rb_state_e         state;
  logic [SYS_AW-1:0] addr_q;
  logic              ce_on;
  logic              oe_on;

  // Named internal events, also used by the bound checker
  logic accept_evt;
  logic oe_set_evt;
  logic last_evt;
  logic rel_evt;

  assign accept_evt = (state == ST_IDLE) && rd_req;
  assign rel_evt    = (state == ST_RELEASE);

  rom_bank_timer #(
    .ACC_CYC(ACC_CYC), .LEAD(LEAD), .CNT_W(CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept_evt),
    .run   (state == ST_ACCESS),
    .oe_set(oe_set_evt),
    .last  (last_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      ce_on  <= 1'b0;
      oe_on  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:    if (accept_evt) state <= ST_ACCESS;
        ST_ACCESS:  if (last_evt)   state <= ST_RELEASE;
        ST_RELEASE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
      if (accept_evt) addr_q <= rd_addr;
      if (accept_evt)   ce_on <= 1'b1;
      else if (rel_evt) ce_on <= 1'b0;
      // output enable drops at the sample point, a cycle before the select
      if (last_evt)        oe_on <= 1'b0;
      else if (oe_set_evt) oe_on <= 1'b1;
    end
  end

  rom_bank_decode #(
    .N_CHIPS(N_CHIPS), .SEL_W(SEL_W)
  ) u_decode (
    .sel (addr_q[SYS_AW-1:DEV_AW]),
    .en  (ce_on),
    .ce_n(chip_ce_n)
  );

  rom_bank_capture #(.DW(DW)) u_capture (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (last_evt),
    .rel  (rel_evt),
    .bus  (dev_data),
    .data (rd_data),
    .done (rd_done)
  );

  assign dev_addr = addr_q[DEV_AW-1:0];
  assign out_en_n = ~oe_on;
  assign rd_ready = (state == ST_IDLE);
endmodule

// File: rtl/rom_bank_reader_chk.sv
`timescale 1ns/1ps
module rom_bank_reader_chk #(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned DEV_AW  = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CHIPS-1:0] ce_n,
  input logic               oe_n,
  input logic [DEV_AW-1:0]  addr,
  input logic               done,
  input logic               ready,
  input logic               last_evt,
  input logic               accept_evt
);
  logic any_ce;
  assign any_ce = (ce_n != {N_CHIPS{1'b1}});

  // R3
  one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);

  // R4
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> $onehot(~ce_n));

  // R6
  oe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ce && $past(any_ce)) |-> $past(oe_n));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ce && $past(any_ce)) |-> ($stable(addr) && $stable(ce_n)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |-> (!oe_n && any_ce));

  // R8
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (ready && !any_ce && oe_n));
endmodule

bind rom_bank_reader rom_bank_reader_chk #(
  .N_CHIPS(N_CHIPS), .DEV_AW(DEV_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (chip_ce_n),
  .oe_n      (out_en_n),
  .addr      (dev_addr),
  .done      (rd_done),
  .ready     (rd_ready),
  .last_evt  (last_evt),
  .accept_evt(accept_evt)
);

// File: tb/rom_bank_reader_test.sv
`timescale 1ns/1ps
module rom_bank_reader_test;
  localparam int N    = 4;
  localparam int AW   = 20;
  localparam int DW   = 8;
  localparam int ACC  = 6;
  localparam int OEC  = 2;
  localparam int LEAD = ACC - OEC;
  localparam int SW   = 2;
  // device model latencies, equal to the sequencer's settings
  localparam int M_ACC = ACC;
  localparam int M_OE  = OEC;

  logic clk = 1'b0;
  logic rst_n;
  logic rd_req;
  logic [AW+SW-1:0] rd_addr;
  logic rd_ready, rd_done, out_en_n;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] dev_addr;
  logic [N-1:0] chip_ce_n;
  logic [DW-1:0] bus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rom_bank_reader #(.N_CHIPS(N), .DEV_AW(AW), .DW(DW), .ACC_CYC(ACC), .OE_CYC(OEC)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_done(rd_done), .rd_data(rd_data),
    .dev_addr(dev_addr), .chip_ce_n(chip_ce_n), .out_en_n(out_en_n),
    .dev_data(bus)
  );

  function automatic logic [7:0] content(input int chip, input logic [AW-1:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ (8'h5A + 8'(chip * 51));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- device models: tri-state output with own latency
  int ce_age [N];
  int oe_age;
  int drivers;
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) ce_age[i] <= chip_ce_n[i] ? 0 : ce_age[i] + 1;
    oe_age <= out_en_n ? 0 : oe_age + 1;
  end
  always @* begin
    drivers = 0;
    bus = 8'hFF;  // idle bus level
    for (int i = 0; i < N; i++) begin
      if (!chip_ce_n[i] && !out_en_n) begin
        drivers++;
        if (ce_age[i] >= M_ACC - 1 && oe_age >= M_OE - 1) bus = content(i, dev_addr);
        else bus = ~content(i, dev_addr);
      end
    end
  end

  // ---------------- behavioural reference, advanced on every clock
  int rt = -1;
  int rchip = 0;
  logic [AW-1:0] raddr = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rt <= -1;
    else if (((rt < 0) || (rt == ACC + 2)) && rd_req) begin
      rt <= 1;
      rchip <= int'(rd_addr[AW+SW-1:AW]);
      raddr <= rd_addr[AW-1:0];
    end else if (rt >= 1 && rt < ACC + 2) rt <= rt + 1;
    else rt <= -1;
  end

  logic prev_act = 1'b0;
  logic prev_oe  = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      logic act;
      logic [N-1:0] e_ce;
      logic e_oe, e_done, e_rdy;
      act   = (rt >= 1 && rt <= ACC + 1);
      e_ce  = act ? ~(N'(1) << rchip) : '1;
      e_oe  = !(rt >= LEAD + 1 && rt <= ACC);
      e_done = (rt == ACC + 2);
      e_rdy = !act;
      chk(chip_ce_n == e_ce, "R2 chip enable", 32'(chip_ce_n), 32'(e_ce));
      chk(out_en_n == e_oe, "R5 output enable", 32'(out_en_n), 32'(e_oe));
      chk(rd_done == e_done, "R7 done", 32'(rd_done), 32'(e_done));
      chk(rd_ready == e_rdy, "R8 ready", 32'(rd_ready), 32'(e_rdy));
      chk(drivers <= 1, "R3 bus contention", 32'(drivers), 32'd1);
      if (act) chk(dev_addr == raddr, "R9 device address", 32'(dev_addr), 32'(raddr));
      if (e_done) chk(rd_data == content(rchip, raddr), "R7 read data",
                      32'(rd_data), 32'(content(rchip, raddr)));
      if (prev_act && chip_ce_n == '1)
        chk(prev_oe == 1'b1, "R6 output enable first", 32'(prev_oe), 32'd1);
      if (!out_en_n) chk($countones(~chip_ce_n) == 1, "R4 oe with select",
                         32'($countones(~chip_ce_n)), 32'd1);
      prev_act <= (chip_ce_n != '1);
      prev_oe  <= out_en_n;
    end
  end

  // ---------------- stimulus
  task automatic read1(input int chip, input logic [AW-1:0] a);
    @(negedge clk);
    rd_req  = 1'b1;
    rd_addr = {SW'(chip), a};
    @(negedge clk);
    rd_req = 1'b0;
    repeat (ACC + 2) @(negedge clk);
  endtask

  logic [15:0] lf = 16'hACE1;

  initial begin
    rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    chk(chip_ce_n == '1 && out_en_n && !rd_done && rd_ready, "R1 reset state",
        {chip_ce_n, out_en_n, rd_done, rd_ready}, {4'hF, 3'b101});
    rst_n = 1'b1;
    @(negedge clk);
    chk(chip_ce_n == '1 && out_en_n && !rd_done && rd_ready, "R1 after reset",
        {chip_ce_n, out_en_n, rd_done, rd_ready}, {4'hF, 3'b101});

    // R2 R7: one read per device at boundary and mixed addresses
    read1(0, 20'h00000);
    read1(1, 20'hFFFFF);
    read1(2, 20'h12345);
    read1(3, 20'hABCDE);
    read1(3, 20'hFFFFF);

    // R8: requests during an access are ignored
    @(negedge clk);
    rd_req = 1'b1; rd_addr = {2'd1, 20'h0F0F0};
    @(negedge clk);
    rd_addr = {2'd2, 20'h33333};
    repeat (3) @(negedge clk);
    rd_addr = {2'd0, 20'h55555};
    @(negedge clk);
    rd_req = 1'b0;
    repeat (ACC) @(negedge clk);
    chk(chip_ce_n == '1 && rd_ready, "R8 ignored request left bank idle",
        32'(chip_ce_n), 32'hF);

    // R8 R6: request held high, back-to-back accesses switching device
    rd_req = 1'b1;
    for (int k = 0; k < 8; k++) begin
      rd_addr = {SW'(k), 20'(k * 20'h1F3A7)};
      repeat (ACC + 2) @(negedge clk);
    end
    rd_req = 1'b0;
    repeat (ACC + 4) @(negedge clk);

    // mixed request patterns
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rd_req  = lf[0] & lf[3];
      rd_addr = {lf[5:4], lf[15:0], lf[9:6]};
      @(negedge clk);
    end
    rd_req = 1'b0;
    repeat (ACC + 4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule